// File: doc/BRIEF.md
# Serial Frame Transmitter with Parity Modes and Receive Parity Check

This block turns parallel bytes into asynchronous serial frames on a single output line, and pairs the transmitter with a receive-side checker that rebuilds incoming frames and reports parity mismatches. A one-byte holding register accepts a byte from the host. The shifter takes it at the next frame boundary and sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Bit timing comes from an oversampling tick that an external divider supplies.

One 8-bit line-control input sets both directions. Bits 1:0 give the word length (5 + value). Bit 2 selects two stop bits. Bit 3 enables parity. Bit 4 picks even rather than odd parity. Bit 5 turns on fixed ("stick") parity. Bit 6 forces the line low as a break. Bit 7 only steers register decoding elsewhere in the chip, so this block ignores it. Word length, stop count and parity settings are captured when a frame starts. Break acts on the line directly: it overrides the output, and the line returns to normal only at the next frame boundary.

Top module: `uart_lc_top`

## Requirements
- R1: The line idles at 1. A frame is a 0 start bit, then 5 + lcr[1:0] data bits with the LSB first, then the parity bit when lcr[3]=1, then one stop bit at 1 (two when lcr[2]=1).
- R2: Each bit on the line lasts OVERSAMPLE pulses of baud_tick.
- R3: With lcr[3]=0 no parity bit is sent and rx_parity_err never rises.
- R4: With lcr[3]=1 and lcr[5]=0, the parity bit makes the count of ones over the data and parity bits odd when lcr[4]=0 and even when lcr[4]=1.
- R5: With lcr[3]=1 and lcr[5]=1, the parity bit is the constant 0 when lcr[4]=1 and the constant 1 when lcr[4]=0. The checker expects the same value.
- R6: While lcr[6]=1, txd is 0 whatever the transmitter is doing.
- R7: If lcr[6] is cleared during a frame, txd stays 1 for the rest of that frame. The next frame is sent normally.
- R8: lcr[7] has no effect on the frames sent or checked.
- R9: A byte offered with tx_load while tx_ready=1 is accepted, and tx_ready is 0 in the next cycle.
- R10: For each received frame, rx_valid pulses for one cycle. rx_data holds the data bits right-aligned, with the unused upper bits at 0. rx_parity_err is 1 in that same cycle exactly when parity is enabled and the received parity bit differs from the value that R4 and R5 give.
- R11: After reset, txd=1, tx_ready=1 and rx_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick from the external divider |
| lcr_i | input | 8 | Line-control byte |
| tx_load | input | 1 | Offer tx_data to the holding register |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Holding register is empty |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_valid | output | 1 | One-cycle pulse when a received frame is complete |
| rx_data | output | 8 | Received data bits, right-aligned |
| rx_parity_err | output | 1 | Parity mismatch, valid together with rx_valid |

## Verification
The bench builds the block with OVERSAMPLE=8 and drives baud_tick on every other clock, so each bit lasts 16 clocks. At that rate every word length, stop count and parity mode can be sent through the loopback path and sampled mid-bit within a short run. The half-bit start qualification of the checker is then only four ticks long, which brings timing against the tick phase within reach. The bench also drives hand-built frames with deliberately wrong parity bits, and releases break partway through a frame.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;

    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic       stick;
        logic       even;
        logic       pen;
        logic       stop2;
        logic [1:0] wlen;
    } lcr_t;

    typedef struct packed {
        logic       stick;
        logic       even;
        logic       pen;
        logic       stop2;
        logic [1:0] wlen;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    function automatic logic [3:0] lc_width(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    function automatic logic [7:0] lc_mask(input logic [1:0] wlen);
        logic [1:0] sh;
        sh = 2'd3 - wlen;
        return 8'hFF >> sh;
    endfunction

    // Bits shifted in from the top end up in the upper positions; move them down.
    function automatic logic [7:0] lc_align(input logic [7:0] sr, input logic [1:0] wlen);
        logic [1:0] sh;
        sh = 2'd3 - wlen;
        return sr >> sh;
    endfunction

    function automatic logic lc_parity(input logic [7:0] d, input frame_cfg_t c);
        logic x;
        x = ^(d & lc_mask(c.wlen));
        if (c.stick)
            return ~c.even;
        return c.even ? x : ~x;
    endfunction

endpackage

// File: rtl/uart_lc_tx.sv
module uart_lc_tx
    import uart_lc_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       load,
    input  logic [7:0] data,
    output logic       ready,
    output logic       line,
    output logic       busy,
    output logic       frame_start
);
    localparam int CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    phase_e        state;
    logic [7:0]    hold_q;
    logic          hold_full;
    logic [7:0]    shreg;
    logic          par_q;
    frame_cfg_t    cfg_q;
    logic [3:0]    idx;
    logic [CW-1:0] tcnt;
    logic          step;

    assign step        = tick && (tcnt == LAST);
    assign frame_start = (state == PH_IDLE) && hold_full;
    assign ready       = !hold_full;
    assign busy        = (state != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            hold_q    <= '0;
            hold_full <= 1'b0;
            shreg     <= '0;
            par_q     <= 1'b0;
            cfg_q     <= '0;
            idx       <= '0;
            tcnt      <= '0;
        end else begin
            if (load && !hold_full) begin
                hold_q    <= data;
                hold_full <= 1'b1;
            end
            if (frame_start) begin
                shreg     <= hold_q;
                par_q     <= lc_parity(hold_q, cfg);
                cfg_q     <= cfg;
                hold_full <= 1'b0;
                state     <= PH_START;
                tcnt      <= '0;
                idx       <= '0;
            end else if (state != PH_IDLE && tick) begin
                tcnt <= step ? '0 : tcnt + 1'b1;
                if (step) begin
                    case (state)
                        PH_START: state <= PH_DATA;
                        PH_DATA: begin
                            shreg <= shreg >> 1;
                            if (idx == lc_width(cfg_q.wlen) - 4'd1) begin
                                idx   <= '0;
                                state <= cfg_q.pen ? PH_PAR : PH_STOP;
                            end else begin
                                idx <= idx + 4'd1;
                            end
                        end
                        PH_PAR: state <= PH_STOP;
                        PH_STOP: begin
                            if (cfg_q.stop2 && idx == 4'd0)
                                idx <= 4'd1;
                            else
                                state <= PH_IDLE;
                        end
                        default: state <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (state)
            PH_START: line = 1'b0;
            PH_DATA:  line = shreg[0];
            PH_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_lc_rx.sv
module uart_lc_rx
    import uart_lc_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data,
    output logic       perr
);
    localparam int CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST      = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE / 2 - 1);

    phase_e        state;
    logic          s1, s2;
    logic [7:0]    shreg;
    logic          par_q;
    logic [3:0]    idx;
    logic [CW-1:0] cnt;
    logic          at_mid;
    logic [7:0]    word;

    assign at_mid = tick && (cnt == LAST);
    assign word   = lc_align(shreg, cfg.wlen);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b1;
            s2    <= 1'b1;
            state <= PH_IDLE;
            shreg <= '0;
            par_q <= 1'b0;
            idx   <= '0;
            cnt   <= '0;
            valid <= 1'b0;
            data  <= '0;
            perr  <= 1'b0;
        end else begin
            s1    <= rxd;
            s2    <= s1;
            valid <= 1'b0;
            perr  <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (tick && !s2) begin
                        state <= PH_START;
                        cnt   <= '0;
                    end
                end
                PH_START: begin
                    if (tick) begin
                        if (cnt == HALF_LAST) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= s2 ? PH_IDLE : PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (tick) cnt <= at_mid ? '0 : cnt + 1'b1;
                    if (at_mid) begin
                        shreg <= {s2, shreg[7:1]};
                        if (idx == lc_width(cfg.wlen) - 4'd1) begin
                            idx   <= '0;
                            state <= cfg.pen ? PH_PAR : PH_STOP;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                end
                PH_PAR: begin
                    if (tick) cnt <= at_mid ? '0 : cnt + 1'b1;
                    if (at_mid) begin
                        par_q <= s2;
                        state <= PH_STOP;
                    end
                end
                PH_STOP: begin
                    if (tick) cnt <= at_mid ? '0 : cnt + 1'b1;
                    if (at_mid) begin
                        if (idx == 4'd0) begin
                            valid <= 1'b1;
                            data  <= word;
                            perr  <= cfg.pen && (par_q != lc_parity(word, cfg));
                            if (cfg.stop2)
                                idx <= 4'd1;
                            else
                                state <= PH_IDLE;
                        end else begin
                            state <= PH_IDLE;
                        end
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_lc_top.sv
module uart_lc_top
    import uart_lc_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic [7:0] lcr_i,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_parity_err
);
    lcr_t       lcr;
    frame_cfg_t cfg;
    logic       unused_dlab;
    logic       tx_line;
    logic       tx_busy;
    logic       tx_start;
    logic       mute_q;

    assign lcr         = lcr_t'(lcr_i);
    assign unused_dlab = lcr.dlab;
    assign cfg         = '{stick: lcr.stick, even: lcr.even, pen: lcr.pen,
                           stop2: lcr.stop2, wlen: lcr.wlen};

    uart_lc_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .tick        (baud_tick),
        .cfg         (cfg),
        .load        (tx_load),
        .data        (tx_data),
        .ready       (tx_ready),
        .line        (tx_line),
        .busy        (tx_busy),
        .frame_start (tx_start)
    );

    uart_lc_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .tick  (baud_tick),
        .cfg   (cfg),
        .rxd   (rxd),
        .valid (rx_valid),
        .data  (rx_data),
        .perr  (rx_parity_err)
    );

    // Once break has been seen, the line stays marking until a new frame begins.
    always_ff @(posedge clk) begin
        if (rst)
            mute_q <= 1'b0;
        else if (lcr.brk)
            mute_q <= 1'b1;
        else if (tx_start)
            mute_q <= 1'b0;
    end

    assign txd = lcr.brk ? 1'b0 : (mute_q ? 1'b1 : tx_line);

endmodule

// File: rtl/uart_lc_chk.sv
module uart_lc_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] lcr_i,
    input logic       tx_load,
    input logic       tx_ready,
    input logic       txd,
    input logic       tx_busy,
    input logic       rx_valid,
    input logic       rx_parity_err
);
    a_r6_break_low: assert property (@(posedge clk) disable iff (rst)
        lcr_i[6] |-> !txd);

    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        (!lcr_i[6] && !tx_busy) |-> txd);

    a_r9_load_fills: assert property (@(posedge clk) disable iff (rst)
        (tx_load && tx_ready) |=> !tx_ready);

    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r10_err_with_valid: assert property (@(posedge clk) disable iff (rst)
        rx_parity_err |-> rx_valid);

    a_r3_no_err_without_parity: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !lcr_i[3]) |-> !rx_parity_err);
endmodule

bind uart_lc_top uart_lc_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .lcr_i         (lcr_i),
    .tx_load       (tx_load),
    .tx_ready      (tx_ready),
    .txd           (txd),
    .tx_busy       (tx_busy),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err)
);

// File: tb/uart_lc_top_bench.sv
`timescale 1ns/1ps
module uart_lc_top_bench;
    localparam int OS  = 8;
    localparam int BIT = 16;   // clocks per bit: OS ticks, one tick every two clocks

    // {lcr, data} stimulus; expected frames are computed from the requirements
    localparam logic [15:0] VEC [9] = '{
        16'h03_A5,  // 8N1
        16'h1A_3C,  // 7 bits, even parity
        16'h0C_13,  // 5 bits, odd parity, 2 stop
        16'h2B_FF,  // 8 bits, mark parity
        16'h3B_01,  // 8 bits, space parity
        16'h1D_2A,  // 6 bits, even parity, 2 stop
        16'h8B_00,  // divisor-access bit set, 8 bits odd
        16'h23_7E,  // stick bit without parity enable
        16'h83_5A   // divisor-access bit set, 8N1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] lcr = 8'h03;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, txd, rx_valid, rx_parity_err;
    logic [7:0] rx_data;
    logic       loop = 1'b1;
    logic       drv_rx = 1'b1;
    logic       rxd_w;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  got_rx  = 1'b0;
    logic [7:0] got_data = 8'h00;
    logic       got_err  = 1'b0;

    assign rxd_w = loop ? txd : drv_rx;

    uart_lc_top #(.OVERSAMPLE(OS)) u_uart_lc_top (
        .clk(clk), .rst(rst), .baud_tick(tick), .lcr_i(lcr),
        .tx_load(tx_load), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd_w), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    initial forever begin
        @(negedge clk);
        if (rx_valid === 1'b1) begin
            got_rx   = 1'b1;
            got_data = rx_data;
            got_err  = rx_parity_err;
        end
    end

    task automatic chk(input bit ok, input string msg, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    function automatic logic ref_par(input logic [7:0] l, input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 5 + int'(l[1:0]); i++) ones += int'(d[i]);
        if (l[5]) return !l[4];
        if (l[4]) return (ones % 2) == 1;
        return (ones % 2) == 0;
    endfunction

    task automatic load_byte(input logic [7:0] d);
        @(negedge clk);
        tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic wait_fall();
        int w = 0;
        while (txd !== 1'b0 && w < 400) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic check_frame(input logic [7:0] l, input logic [7:0] d, input string tag);
        logic [15:0] exp_bits = '1;
        logic [15:0] got_bits = '1;
        int len = 0;
        exp_bits[len] = 1'b0;
        len++;
        for (int i = 0; i < 5 + int'(l[1:0]); i++) begin
            exp_bits[len] = d[i];
            len++;
        end
        if (l[3]) begin
            exp_bits[len] = ref_par(l, d);
            len++;
        end
        len += l[2] ? 2 : 1;
        wait_fall();
        repeat (BIT / 2) @(negedge clk);
        got_bits[0] = txd;
        for (int k = 1; k < len; k++) begin
            repeat (BIT) @(negedge clk);
            got_bits[k] = txd;
        end
        chk(got_bits == exp_bits, tag, got_bits, exp_bits);
    endtask

    task automatic send_rx(input int nbits, input logic [7:0] d, input bit has_par, input logic pbit);
        drv_rx = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            drv_rx = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (has_par) begin
            drv_rx = pbit;
            repeat (BIT) @(negedge clk);
        end
        drv_rx = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(txd === 1'b1 && tx_ready === 1'b1 && rx_valid === 1'b0, "R11 reset outputs",
            {13'd0, txd, tx_ready, rx_valid}, 16'h0006);

        // Vector table: R1 R2 R3 R4 R5 R8 on the line, R10 through loopback
        for (int v = 0; v < 9; v++) begin
            lcr    = VEC[v][15:8];
            loop   = 1'b1;
            got_rx = 1'b0;
            load_byte(VEC[v][7:0]);
            check_frame(VEC[v][15:8], VEC[v][7:0], "R1 R3 R4 R5 R8 frame bits");
            repeat (24) @(negedge clk);
            chk(got_rx && got_data == (VEC[v][7:0] & (8'hFF >> (3 - int'(VEC[v][9:8])))) && !got_err,
                "R10 loopback byte",
                {7'd0, got_rx, got_data}, {8'h01, VEC[v][7:0] & (8'hFF >> (3 - int'(VEC[v][9:8])))});
        end

        // R2: start bit length in clocks
        begin
            int low = 0;
            lcr = 8'h03;
            load_byte(8'h01);
            wait_fall();
            while (txd === 1'b0 && low < 100) begin
                @(negedge clk);
                low++;
            end
            chk(low >= BIT - 2 && low <= BIT + 1, "R2 start bit duration", 16'(low), 16'(BIT));
            repeat (12 * BIT) @(negedge clk);
        end

        // R9: holding register accepts and reports full next cycle
        @(negedge clk);
        chk(tx_ready === 1'b1, "R9 ready before load", {15'd0, tx_ready}, 16'h1);
        tx_data = 8'h6C;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        chk(tx_ready === 1'b0, "R9 ready low after load", {15'd0, tx_ready}, 16'h0);
        check_frame(8'h03, 8'h6C, "R9 accepted byte sent");
        repeat (2 * BIT) @(negedge clk);

        // R6 and R7: break override and release mid-frame
        begin
            int bad = 0;
            loop = 1'b0;
            lcr  = 8'h43;
            load_byte(8'hC3);
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (txd !== 1'b0) bad++;
            end
            chk(bad == 0, "R6 break holds line low", 16'(bad), 16'd0);
            lcr = 8'h03;
            bad = 0;
            load_byte(8'h96);
            for (int i = 0; i < 98; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) bad++;
            end
            chk(bad == 0, "R7 line marking after release", 16'(bad), 16'd0);
            check_frame(8'h03, 8'h96, "R7 next frame normal");
            repeat (2 * BIT) @(negedge clk);
        end

        // R10 parity error detection on hand-built frames
        lcr = 8'h1B; got_rx = 1'b0;
        send_rx(8, 8'h35, 1'b1, 1'b1);
        chk(got_rx && got_err && got_data == 8'h35, "R10 even parity wrong bit",
            {6'd0, got_rx, got_err, got_data}, 16'h0335);
        lcr = 8'h2B; got_rx = 1'b0;
        send_rx(8, 8'h0F, 1'b1, 1'b0);
        chk(got_rx && got_err, "R5 mark parity received as 0",
            {6'd0, got_rx, got_err, got_data}, 16'h030F);
        lcr = 8'h3B; got_rx = 1'b0;
        send_rx(8, 8'h80, 1'b1, 1'b0);
        chk(got_rx && !got_err && got_data == 8'h80, "R5 space parity accepted",
            {6'd0, got_rx, got_err, got_data}, 16'h0280);
        lcr = 8'h08; got_rx = 1'b0;
        send_rx(5, 8'h1F, 1'b1, 1'b0);
        chk(got_rx && !got_err && got_data == 8'h1F, "R4 odd parity 5-bit accepted",
            {6'd0, got_rx, got_err, got_data}, 16'h021F);
        lcr = 8'h03; got_rx = 1'b0;
        send_rx(8, 8'hC4, 1'b1, 1'b1);
        chk(got_rx && !got_err && got_data == 8'hC4, "R3 no parity check when disabled",
            {6'd0, got_rx, got_err, got_data}, 16'h02C4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule